// File: doc/BRIEF.md
# Paged monitor register window

This block is the host-side register window of a hardware-monitor function. It decodes a 256-byte I/O space behind a byte-wide host bus that has an offset, a write strobe, a read strobe, write data and registered read data. Sixteen pages of monitor registers share one window. A page-select register chooses which page the window reaches.

A write-control register protects the window. While its bit 0 is clear, host writes land in the selected page. While the bit is set, host writes are dropped. Setting the bit again after an update commits the update. The commit raises a single-cycle notification toward the internal monitor logic and loads the fan PWM duty output. The duty output is driven from a fixed byte in page 1.

Reads work at any time. They ignore the write-control bit.

Top module: `hwmon_page_window`

## Requirements
- R1: Reset state. After the synchronous active-high reset:
  - page 0 is selected;
  - write-control bit 0 is 1 (locked);
  - every page byte is 0x00;
  - `fan_duty` is 0x00, `mon_commit` is 0 and `hb_rdata` is 0x00.
- R2: Read timing. A read is captured on the clock edge where `hb_rd` is high, and `hb_rdata` shows the value from the next cycle on. `hb_rdata` keeps its value in every cycle that follows an edge without `hb_rd`.
- R3: Offset 0x04 is the write-control register. A write stores bit 0 of `hb_wdata`. A read returns {7'b0, bit0}.
- R4: Offsets 0x10 to 0xFE form the window into the selected page.
  - A write there is stored only while write-control bit 0 is 0.
  - While the bit is 1, the write leaves all storage unchanged.
- R5: Window reads return the selected page's byte whatever the write-control bit is.
- R6: Offset 0xFF is the page register. A write keeps `hb_wdata[3:0]` as the page number. A read returns {4'b0, page}. The new page applies to the very next access.
- R7: Each page has its own storage. A write to an offset in one page leaves that offset in every other page unchanged.
- R8: Commit pulse.
  - A write to 0x04 with bit 0 = 1 while the stored bit is 0 raises `mon_commit` for exactly the one cycle after that write's edge.
  - Writing bit 0 = 1 while it is already 1, or writing bit 0 = 0, gives no pulse.
- R9: `fan_duty` loads the page-1 byte at offset 0x98 on the edge that ends the commit pulse. At all other times it holds its value.
- R10: Offsets 0x00 to 0x0F other than 0x04 are unmapped. Reads there return 0x00 and writes there have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_addr | input | 8 | Byte offset within the 256-byte space |
| hb_wr | input | 1 | Write strobe, captured on the rising edge |
| hb_rd | input | 1 | Read strobe, captured on the rising edge |
| hb_wdata | input | 8 | Write data |
| hb_rdata | output | 8 | Registered read data, valid one cycle after the read strobe |
| mon_commit | output | 1 | One-cycle notice that the host committed new data |
| fan_duty | output | 8 | Fan PWM duty value, loaded on commit |

## Verification
The bench aims at the following corner cases, each named with the faulty behaviour it would expose:
- **Locked writes.** A design that ignored the lock would change storage on a locked window write.
- **Page switch then access.** A design that delayed the page change would read or write the previous page on the access right after the switch.
- **Repeated lock writes.** A design that treated a repeated lock write as a commit would pulse `mon_commit` with no 0-to-1 change of the bit.
- **Fan byte written without commit.** A design that did not wait for the commit would move `fan_duty` as soon as the page-1 byte at 0x98 was written.
- **Window edges.** The bench writes and reads 0x10 and 0xFE to catch an off-by-one error in the window range.
- **Unmapped offsets.** The bench reads unmapped low offsets and the unused bits of both control registers to catch stray data.
- **Idle cycles.** The bench checks that `hb_rdata` stays put when no read is issued.

// File: rtl/hwmon_pkg.sv
package hwmon_pkg;

    localparam int HB_AW = 8;

    typedef logic [HB_AW-1:0] hb_addr_t;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_CTRL = 2'd1,
        RGN_PAGE = 2'd2,
        RGN_WIN  = 2'd3
    } rgn_e;

    typedef struct packed {
        rgn_e     rgn;
        hb_addr_t win_idx;
    } hb_dec_t;

    // Classify an offset and compute its index inside the window.
    function automatic hb_dec_t decode_offset(
        input hb_addr_t addr,
        input hb_addr_t ctrl_ofs,
        input hb_addr_t page_ofs,
        input hb_addr_t win_lo,
        input hb_addr_t win_hi
    );
        hb_dec_t d;
        d.win_idx = addr - win_lo;
        if (addr == ctrl_ofs)
            d.rgn = RGN_CTRL;
        else if (addr == page_ofs)
            d.rgn = RGN_PAGE;
        else if (addr >= win_lo && addr <= win_hi)
            d.rgn = RGN_WIN;
        else
            d.rgn = RGN_NONE;
        return d;
    endfunction

endpackage

// File: rtl/hwmon_decode.sv
module hwmon_decode
    import hwmon_pkg::*;
#(
    parameter hb_addr_t CTRL_OFS = 8'h04,
    parameter hb_addr_t PAGE_OFS = 8'hFF,
    parameter hb_addr_t WIN_LO   = 8'h10,
    parameter hb_addr_t WIN_HI   = 8'hFE
) (
    input  hb_addr_t addr,
    input  logic     wr,
    output hb_dec_t  dec,
    output logic     win_we,
    output logic     ctrl_we,
    output logic     page_we
);

    always_comb begin
        dec     = decode_offset(addr, CTRL_OFS, PAGE_OFS, WIN_LO, WIN_HI);
        win_we  = wr && (dec.rgn == RGN_WIN);
        ctrl_we = wr && (dec.rgn == RGN_CTRL);
        page_we = wr && (dec.rgn == RGN_PAGE);
    end

endmodule

// File: rtl/hwmon_ctrl.sv
module hwmon_ctrl #(
    parameter int PAGE_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctrl_we,
    input  logic                 page_we,
    input  logic                 wbit0,
    input  logic [PAGE_BITS-1:0] wpage,
    output logic                 lock_q,
    output logic [PAGE_BITS-1:0] page_q,
    output logic                 commit_q
);

    logic commit_d;

    // Commit only on a 0-to-1 change of the stored lock bit.
    assign commit_d = ctrl_we && wbit0 && !lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q   <= 1'b1;
            page_q   <= '0;
            commit_q <= 1'b0;
        end else begin
            commit_q <= commit_d;
            if (ctrl_we)
                lock_q <= wbit0;
            if (page_we)
                page_q <= wpage;
        end
    end

endmodule

// File: rtl/hwmon_bank.sv
module hwmon_bank #(
    parameter int DATA_W  = 8,
    parameter int DEPTH   = 239,
    parameter int IDX_W   = 8,
    parameter bit TAP_EN  = 1'b0,
    parameter int TAP_IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_byte,
    output logic [DATA_W-1:0] tap_byte
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic              idx_ok;

    assign idx_ok = (idx < IDX_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (we && idx_ok) begin
            mem[idx] <= wdata;
        end
    end

    assign rd_byte = idx_ok ? mem[idx] : '0;

    generate
        if (TAP_EN) begin : g_tap
            assign tap_byte = mem[TAP_IDX];
        end else begin : g_no_tap
            assign tap_byte = '0;
        end
    endgenerate

endmodule

// File: rtl/hwmon_page_window.sv
module hwmon_page_window
    import hwmon_pkg::*;
#(
    parameter int       DATA_W    = 8,
    parameter int       PAGE_BITS = 4,
    parameter hb_addr_t CTRL_OFS  = 8'h04,
    parameter hb_addr_t PAGE_OFS  = 8'hFF,
    parameter hb_addr_t WIN_LO    = 8'h10,
    parameter hb_addr_t WIN_HI    = 8'hFE,
    parameter int       FAN_PAGE  = 1,
    parameter hb_addr_t FAN_OFS   = 8'h98
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        hb_addr,
    input  logic              hb_wr,
    input  logic              hb_rd,
    input  logic [DATA_W-1:0] hb_wdata,
    output logic [DATA_W-1:0] hb_rdata,
    output logic              mon_commit,
    output logic [DATA_W-1:0] fan_duty
);

    localparam int PAGES     = 1 << PAGE_BITS;
    localparam int WIN_DEPTH = int'(WIN_HI) - int'(WIN_LO) + 1;
    localparam int FAN_IDX   = int'(FAN_OFS) - int'(WIN_LO);

    hb_dec_t              dec;
    logic                 win_we, ctrl_we, page_we;
    logic                 lock_q;
    logic [PAGE_BITS-1:0] page_q;
    logic                 commit_q;
    logic [DATA_W-1:0]    bank_rd  [PAGES];
    logic [DATA_W-1:0]    bank_tap [PAGES];
    logic [PAGES-1:0]     bank_we;
    logic [DATA_W-1:0]    win_rd;
    logic [DATA_W-1:0]    fan_src;
    logic [DATA_W-1:0]    rdata_d;
    logic [DATA_W-1:0]    rdata_q;
    logic [DATA_W-1:0]    fan_q;

    hwmon_decode #(
        .CTRL_OFS (CTRL_OFS),
        .PAGE_OFS (PAGE_OFS),
        .WIN_LO   (WIN_LO),
        .WIN_HI   (WIN_HI)
    ) u_dec (
        .addr    (hb_addr),
        .wr      (hb_wr),
        .dec     (dec),
        .win_we  (win_we),
        .ctrl_we (ctrl_we),
        .page_we (page_we)
    );

    hwmon_ctrl #(
        .PAGE_BITS (PAGE_BITS)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ctrl_we  (ctrl_we),
        .page_we  (page_we),
        .wbit0    (hb_wdata[0]),
        .wpage    (hb_wdata[PAGE_BITS-1:0]),
        .lock_q   (lock_q),
        .page_q   (page_q),
        .commit_q (commit_q)
    );

    generate
        for (genvar p = 0; p < PAGES; p++) begin : g_page
            assign bank_we[p] = win_we && !lock_q && (page_q == PAGE_BITS'(p));

            hwmon_bank #(
                .DATA_W  (DATA_W),
                .DEPTH   (WIN_DEPTH),
                .IDX_W   (HB_AW),
                .TAP_EN  (p == FAN_PAGE),
                .TAP_IDX (FAN_IDX)
            ) u_bank (
                .clk      (clk),
                .rst      (rst),
                .we       (bank_we[p]),
                .idx      (dec.win_idx),
                .wdata    (hb_wdata),
                .rd_byte  (bank_rd[p]),
                .tap_byte (bank_tap[p])
            );
        end
    endgenerate

    // Only the fan page drives a non-zero tap, so an OR merge selects it.
    always_comb begin
        fan_src = '0;
        for (int p = 0; p < PAGES; p++)
            fan_src = fan_src | bank_tap[p];
    end

    assign win_rd = bank_rd[page_q];

    always_comb begin
        unique case (dec.rgn)
            RGN_CTRL: rdata_d = DATA_W'(lock_q);
            RGN_PAGE: rdata_d = DATA_W'(page_q);
            RGN_WIN:  rdata_d = win_rd;
            default:  rdata_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            fan_q   <= '0;
        end else begin
            if (hb_rd)
                rdata_q <= rdata_d;
            if (commit_q)
                fan_q <= fan_src;
        end
    end

    assign hb_rdata   = rdata_q;
    assign mon_commit = commit_q;
    assign fan_duty   = fan_q;

endmodule

// File: rtl/hwmon_page_window_chk.sv
module hwmon_page_window_chk #(
    parameter int         DATA_W   = 8,
    parameter logic [7:0] CTRL_OFS = 8'h04,
    parameter logic [7:0] PAGE_OFS = 8'hFF,
    parameter logic [7:0] WIN_LO   = 8'h10
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        hb_addr,
    input logic              hb_wr,
    input logic              hb_rd,
    input logic [DATA_W-1:0] hb_wdata,
    input logic [DATA_W-1:0] hb_rdata,
    input logic              mon_commit,
    input logic [DATA_W-1:0] fan_duty
);

    // R8
    commit_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        mon_commit |=> !mon_commit);

    // R8
    commit_cause_chk: assert property (@(posedge clk) disable iff (rst)
        mon_commit |-> $past(hb_wr && hb_addr == CTRL_OFS && hb_wdata[0]));

    // R9
    fan_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(mon_commit) |-> $stable(fan_duty));

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(hb_rd) |-> $stable(hb_rdata));

    // R6
    page_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(hb_rd && hb_addr == PAGE_OFS) |-> hb_rdata[DATA_W-1:4] == '0);

    // R3
    ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(hb_rd && hb_addr == CTRL_OFS) |-> hb_rdata[DATA_W-1:1] == '0);

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(hb_rd && hb_addr < WIN_LO && hb_addr != CTRL_OFS) |-> hb_rdata == '0);

endmodule

bind hwmon_page_window hwmon_page_window_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .hb_addr    (hb_addr),
    .hb_wr      (hb_wr),
    .hb_rd      (hb_rd),
    .hb_wdata   (hb_wdata),
    .hb_rdata   (hb_rdata),
    .mon_commit (mon_commit),
    .fan_duty   (fan_duty)
);

// File: tb/tb_hwmon_page_window.sv
module tb_hwmon_page_window;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] hb_addr = '0;
    logic       hb_wr = 1'b0;
    logic       hb_rd = 1'b0;
    logic [7:0] hb_wdata = '0;
    logic [7:0] hb_rdata;
    logic       mon_commit;
    logic [7:0] fan_duty;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] mdl [16][256];
    logic [3:0] m_page;
    logic       m_lock;
    logic [7:0] m_fan;
    logic       m_commit;

    always #2 clk = ~clk;

    hwmon_page_window dut (
        .clk        (clk),
        .rst        (rst),
        .hb_addr    (hb_addr),
        .hb_wr      (hb_wr),
        .hb_rd      (hb_rd),
        .hb_wdata   (hb_wdata),
        .hb_rdata   (hb_rdata),
        .mon_commit (mon_commit),
        .fan_duty   (fan_duty)
    );

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        if (a == 8'h04) return {7'b0, m_lock};
        if (a == 8'hFF) return {4'b0, m_page};
        if (a >= 8'h10) return mdl[m_page][a];
        return 8'h00;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        hb_addr = a; hb_wdata = d; hb_wr = 1'b1;
        @(negedge clk);
        hb_wr = 1'b0;
        m_commit = 1'b0;
        if (a == 8'h04) begin
            m_commit = !m_lock && d[0];
            m_lock   = d[0];
        end else if (a == 8'hFF) begin
            m_page = d[3:0];
        end else if (a >= 8'h10 && !m_lock) begin
            mdl[m_page][a] = d;
        end
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        @(negedge clk);
        hb_addr = a; hb_rd = 1'b1;
        @(negedge clk);
        hb_rd = 1'b0;
        check(req, hb_rdata, exp_read(a));
    endtask

    // Control write followed by commit and fan checks (R8, R9).
    task automatic set_lock(input logic [7:0] d);
        wr(8'h04, d);
        check("R8 commit", {7'b0, mon_commit}, {7'b0, m_commit});
        if (m_commit) m_fan = mdl[1][8'h98];
        @(negedge clk);
        check("R8 pulse width", {7'b0, mon_commit}, 8'h00);
        check("R9 fan duty", fan_duty, m_fan);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] last;
        void'($urandom(32'h5eed_1234));
        for (int p = 0; p < 16; p++)
            for (int a = 0; a < 256; a++)
                mdl[p][a] = 8'h00;
        m_page = 4'd0; m_lock = 1'b1; m_fan = 8'h00; m_commit = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 rdata", hb_rdata, 8'h00);
        check("R1 fan", fan_duty, 8'h00);
        check("R1 commit", {7'b0, mon_commit}, 8'h00);
        rd(8'h04, "R1 lock set");
        rd(8'hFF, "R1 page zero");
        rd(8'h20, "R1 storage zero");

        // R4 write while locked is dropped
        wr(8'h20, 8'hAA);
        rd(8'h20, "R4 locked write ignored");

        // unlock, then write and read back
        set_lock(8'h00);
        wr(8'h20, 8'h5A);
        rd(8'h20, "R4 unlocked write");
        wr(8'h10, 8'h11);
        wr(8'hFE, 8'hEE);
        rd(8'h10, "R4 window low edge");
        rd(8'hFE, "R4 window high edge");

        // R6 / R7 page switch takes effect at once
        wr(8'hFF, 8'hF3);
        rd(8'hFF, "R6 page readback");
        rd(8'h20, "R7 other page empty");
        wr(8'h20, 8'h33);
        rd(8'h20, "R7 page3 write");
        wr(8'hFF, 8'h00);
        rd(8'h20, "R7 page0 kept");

        // R8 / R9 fan duty through commit
        wr(8'hFF, 8'h01);
        wr(8'h98, 8'h80);
        check("R9 fan before commit", fan_duty, 8'h00);
        set_lock(8'h01);
        check("R9 fan after commit", fan_duty, 8'h80);
        set_lock(8'h01);
        rd(8'h98, "R5 read while locked");
        set_lock(8'h00);
        wr(8'h98, 8'h40);
        repeat (3) @(negedge clk);
        check("R9 fan holds without commit", fan_duty, 8'h80);
        set_lock(8'hFF);

        // R10 unmapped offsets, R3 control bits
        wr(8'h07, 8'hFF);
        rd(8'h07, "R10 unmapped read");
        rd(8'h00, "R10 offset zero");
        set_lock(8'hFE);
        rd(8'h04, "R3 control readback");

        // R2 read data holds while idle
        rd(8'h98, "R2 read");
        last = hb_rdata;
        repeat (3) @(negedge clk);
        check("R2 hold", hb_rdata, last);

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [7:0] a;
            op = int'($urandom % 7);
            case (op)
                0, 1: begin
                    a = (($urandom % 4) == 0) ? 8'h98 : 8'(8'h10 + ($urandom % 239));
                    wr(a, 8'($urandom));
                end
                2: wr(8'hFF, 8'($urandom % 4));
                3: set_lock(8'($urandom));
                4: wr(8'($urandom % 16), 8'($urandom));
                default: rd(8'($urandom), "R4 R5 R6 R7 random read");
            endcase
        end
        check("R9 fan final", fan_duty, m_fan);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule